// File: doc/BRIEF.md
# Interconnect ECC Checker Injection Controller

This block drives error injection into a bank of interconnect ECC or parity checkers and keeps the interrupt-pending accounting for the results they report. Software uses a simple register bus to choose a target checker group, a first bit index, a second bit index, a fill data pattern and the kind of injection (single or double). The block presents these settings to the checkers, issues a one-cycle injection request, then waits for the targeted group to report back. Once that result arrives, the injection is complete and the force bits clear themselves. If stepping is enabled, the target also moves on to the next bit, or to the next group.

Results from the checkers arrive as a valid strobe with corrected and uncorrected flags, the reporting group and the failing bit (or parity segment). A result from the targeted group while an injection is outstanding counts as injected. Any other result counts as a real error. There are four 2-bit pending counts: real corrected, real uncorrected, injected corrected and injected uncorrected. Software raises a count by writing the add register and lowers it by writing the subtract register. The corrected interrupt and the uncorrected interrupt follow these counts.

The control sequencer has three states. In IDLE it waits for a force bit. The transition IDLE to ISSUE is taken when force-single or force-double is set. In ISSUE the request pulse is driven, and ISSUE always goes to WAIT on the next cycle. In WAIT the block holds the target. WAIT goes back to IDLE when a valid result carries the targeted group number.

Register map (word index on `wr_addr`/`rd_addr`):
- 0 CONTROL: [1:0] fill code, [2] check enable, [3] step enable, [4] force single, [5] force double.
- 1 TARGET: [7:0] group, [20:16] first bit.
- 2 SECOND: [4:0] second bit.
- 3 PEND_ADD and 4 PEND_SUB: both read as the counts. Fields are [1:0] real corrected, [3:2] real uncorrected, [5:4] injected corrected, [7:6] injected uncorrected.
- 5 CAPTURE (read only): [7:0] last reporting group, [20:16] last failing bit.

Top module: `ecc_inj_ctrl`

## Requirements
- R1: After reset, check enable reads 1 and every other CONTROL bit reads 0. TARGET, SECOND, CAPTURE and all four counts read 0. Both interrupts are low and `inj_req` is low.
- R2: `inj_data` is set by the fill code. Code 0 gives all zeros and code 1 gives all ones. Code 2 sets the odd bits (hex A pattern). Code 3 sets the even bits (hex 5 pattern).
- R3: Setting a force bit while IDLE sends the sequencer to ISSUE on the next edge. In ISSUE, `inj_req` is high for exactly one cycle, and the sequencer then enters WAIT. A valid result whose group equals `inj_grp` completes the injection, and both force bits then read 0. `inj_double` is high when force double is set.
- R4: `inj_bit2` carries the second bit index only when force double is set; otherwise it is 0.
- R5: With step enable set, completion advances the first bit by one. At bit 31 the first bit wraps to 0 and the group advances by one. With step enable clear, TARGET is unchanged.
- R6: A write to PEND_ADD adds each 2-bit field to its count, saturating at 3.
- R7: A write to PEND_SUB subtracts each 2-bit field from its count, stopping at 0.
- R8: While checking is enabled, a valid result from the targeted group during WAIT adds 1 to the injected corrected and/or injected uncorrected count, following its flags. Any other valid result adds 1 to the real counts. All of these increments saturate at 3.
- R9: `irq_cor` is high exactly while the real or injected corrected count is nonzero. `irq_unc` is high exactly while the real or injected uncorrected count is nonzero.
- R10: Each counted result with either flag set loads its group and bit into CAPTURE.
- R11: With check enable clear, results change no count and no CAPTURE field.
- R12: While an injection is in progress (ISSUE or WAIT), writes to the force bits, TARGET and SECOND are ignored. The other CONTROL bits are still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write index |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read index |
| rd_data | output | 32 | Register read data (combinational) |
| inj_req | output | 1 | One-cycle injection request |
| inj_double | output | 1 | Injection is double-bit |
| inj_grp | output | 8 | Targeted checker group |
| inj_bit1 | output | 5 | First bit to corrupt |
| inj_bit2 | output | 5 | Second bit to corrupt (double only) |
| inj_data | output | 32 | Injection fill data |
| rsp_valid | input | 1 | Checker result strobe |
| rsp_cor | input | 1 | Result is a corrected error |
| rsp_unc | input | 1 | Result is an uncorrected error |
| rsp_grp | input | 8 | Reporting checker group |
| rsp_bit | input | 5 | Failing bit or parity segment |
| irq_cor | output | 1 | Corrected-error interrupt |
| irq_unc | output | 1 | Uncorrected-error interrupt |

## Verification
The assertions check on every cycle that ISSUE always leads straight to WAIT and that the target stays fixed while waiting. They also check that completion clears both force bits, that a lone event adds exactly one to a count below 3, and that a subtract of at least the current value empties a count. Only the bench scenarios can show the register-visible results. These are the fill patterns, the wrap from bit 31 into the next group, the split between real and injected counts, saturation at 3 and floor at 0, the capture contents, the effect of disabled checking, and the writes ignored while busy.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } inj_state_e;

    localparam logic [2:0] A_CTRL    = 3'd0;
    localparam logic [2:0] A_TARGET  = 3'd1;
    localparam logic [2:0] A_SECOND  = 3'd2;
    localparam logic [2:0] A_PADD    = 3'd3;
    localparam logic [2:0] A_PSUB    = 3'd4;
    localparam logic [2:0] A_CAPTURE = 3'd5;

    localparam int BIT1_LSB = 16;
endpackage

// File: rtl/ecc_inj_seq.sv
module ecc_inj_seq
    import ecc_inj_pkg::*;
#(
    parameter int GRP_W    = 8,
    parameter int GRP_BITS = 32,
    parameter int REG_W    = 32,
    localparam int BIT_W   = $clog2(GRP_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             target_we,
    input  logic             second_we,
    input  logic [REG_W-1:0] wdata,
    input  logic             rsp_valid,
    input  logic [GRP_W-1:0] rsp_grp,
    output logic [1:0]       fill_code,
    output logic             check_en,
    output logic             step_en,
    output logic             force_single,
    output logic             force_double,
    output logic [GRP_W-1:0] grp,
    output logic [BIT_W-1:0] bit1,
    output logic [BIT_W-1:0] bit2,
    output logic             issue,
    output logic             waiting
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(GRP_BITS - 1);

    inj_state_e state, state_nx;
    logic       busy;
    logic       done;

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_WAIT) && rsp_valid && (rsp_grp == grp);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (force_single || force_double) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = ST_WAIT;
            ST_WAIT:  if (done) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        issue   = 1'b0;
        waiting = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ISSUE: issue = 1'b1;
            ST_WAIT:  waiting = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_code    <= 2'd0;
            check_en     <= 1'b1;
            step_en      <= 1'b0;
            force_single <= 1'b0;
            force_double <= 1'b0;
            grp          <= '0;
            bit1         <= '0;
            bit2         <= '0;
        end else begin
            if (ctrl_we) begin
                fill_code <= wdata[1:0];
                check_en  <= wdata[2];
                step_en   <= wdata[3];
                if (!busy) begin
                    force_single <= wdata[4];
                    force_double <= wdata[5];
                end
            end
            if (target_we && !busy) begin
                grp  <= wdata[GRP_W-1:0];
                bit1 <= wdata[BIT1_LSB +: BIT_W];
            end
            if (second_we && !busy) bit2 <= wdata[BIT_W-1:0];
            if (done) begin
                force_single <= 1'b0;
                force_double <= 1'b0;
                if (step_en) begin
                    if (bit1 == LAST_BIT) begin
                        bit1 <= '0;
                        grp  <= grp + 1'b1;
                    end else begin
                        bit1 <= bit1 + 1'b1;
                    end
                end
            end
        end
    end

    a_r3_issue_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE) |=> (state == ST_WAIT));
    a_r12_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WAIT) && !done) |=> ($stable(grp) && $stable(bit1) && $stable(bit2)));
    a_r3_force_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!force_single && !force_double));
endmodule

// File: rtl/ecc_pend_cnt.sv
module ecc_pend_cnt (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev,
    input  logic       add_en,
    input  logic [1:0] add_val,
    input  logic       sub_en,
    input  logic [1:0] sub_val,
    output logic [1:0] cnt
);
    logic [3:0] sum;
    logic [1:0] sat;
    logic [1:0] nxt;

    always_comb begin
        sum = {2'b00, cnt} + {3'b000, ev};
        if (add_en) sum = sum + {2'b00, add_val};
        sat = (sum > 4'd3) ? 2'd3 : sum[1:0];
        nxt = sat;
        if (sub_en) nxt = (sat > sub_val) ? (sat - sub_val) : 2'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= 2'd0;
        else        cnt <= nxt;
    end

    a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && !add_en && !sub_en && (cnt != 2'd3)) |=> (cnt == $past(cnt) + 2'd1));
    a_r7_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_en && !ev && !add_en && (sub_val >= cnt)) |=> (cnt == 2'd0));
endmodule

// File: rtl/ecc_inj_ctrl.sv
module ecc_inj_ctrl
    import ecc_inj_pkg::*;
#(
    parameter int GRP_W    = 8,
    parameter int GRP_BITS = 32,
    parameter int DATA_W   = 32,
    parameter int REG_W    = 32,
    localparam int BIT_W   = $clog2(GRP_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [2:0]        rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              inj_req,
    output logic              inj_double,
    output logic [GRP_W-1:0]  inj_grp,
    output logic [BIT_W-1:0]  inj_bit1,
    output logic [BIT_W-1:0]  inj_bit2,
    output logic [DATA_W-1:0] inj_data,
    input  logic              rsp_valid,
    input  logic              rsp_cor,
    input  logic              rsp_unc,
    input  logic [GRP_W-1:0]  rsp_grp,
    input  logic [BIT_W-1:0]  rsp_bit,
    output logic              irq_cor,
    output logic              irq_unc
);
    localparam int NCNT = 4;

    logic [1:0]       fill_code;
    logic             check_en, step_en, f_single, f_double, waiting;
    logic [GRP_W-1:0] grp;
    logic [BIT_W-1:0] bit1, bit2;
    logic [GRP_W-1:0] cap_grp;
    logic [BIT_W-1:0] cap_bit;
    logic             is_inj;
    logic [NCNT-1:0]  ev;
    logic [1:0]       cnt [NCNT];
    logic [7:0]       cnt_flat;

    ecc_inj_seq #(.GRP_W(GRP_W), .GRP_BITS(GRP_BITS), .REG_W(REG_W)) u_seq (
        .clk, .rst_n,
        .ctrl_we   (wr_en && wr_addr == A_CTRL),
        .target_we (wr_en && wr_addr == A_TARGET),
        .second_we (wr_en && wr_addr == A_SECOND),
        .wdata     (wr_data),
        .rsp_valid, .rsp_grp,
        .fill_code, .check_en, .step_en,
        .force_single (f_single),
        .force_double (f_double),
        .grp, .bit1, .bit2,
        .issue   (inj_req),
        .waiting (waiting)
    );

    assign is_inj = waiting && (rsp_grp == grp);
    assign ev[0]  = check_en && rsp_valid && rsp_cor && !is_inj;
    assign ev[1]  = check_en && rsp_valid && rsp_unc && !is_inj;
    assign ev[2]  = check_en && rsp_valid && rsp_cor && is_inj;
    assign ev[3]  = check_en && rsp_valid && rsp_unc && is_inj;

    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
        ecc_pend_cnt u_cnt (
            .clk, .rst_n,
            .ev      (ev[c]),
            .add_en  (wr_en && wr_addr == A_PADD),
            .add_val (wr_data[2*c +: 2]),
            .sub_en  (wr_en && wr_addr == A_PSUB),
            .sub_val (wr_data[2*c +: 2]),
            .cnt     (cnt[c])
        );
        assign cnt_flat[2*c +: 2] = cnt[c];
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_fill
        assign inj_data[i] = (fill_code == 2'd1) ||
                             ((fill_code == 2'd2) && (i % 2 == 1)) ||
                             ((fill_code == 2'd3) && (i % 2 == 0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_grp <= '0;
            cap_bit <= '0;
        end else if (check_en && rsp_valid && (rsp_cor || rsp_unc)) begin
            cap_grp <= rsp_grp;
            cap_bit <= rsp_bit;
        end
    end

    assign inj_double = f_double;
    assign inj_grp    = grp;
    assign inj_bit1   = bit1;
    assign inj_bit2   = f_double ? bit2 : '0;
    assign irq_cor    = (cnt[0] != 2'd0) || (cnt[2] != 2'd0);
    assign irq_unc    = (cnt[1] != 2'd0) || (cnt[3] != 2'd0);

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:    rd_data[5:0] = {f_double, f_single, step_en, check_en, fill_code};
            A_TARGET: begin
                rd_data[GRP_W-1:0]           = grp;
                rd_data[BIT1_LSB +: BIT_W]   = bit1;
            end
            A_SECOND:  rd_data[BIT_W-1:0] = bit2;
            A_PADD,
            A_PSUB:    rd_data[7:0] = cnt_flat;
            A_CAPTURE: begin
                rd_data[GRP_W-1:0]           = cap_grp;
                rd_data[BIT1_LSB +: BIT_W]   = cap_bit;
            end
            default:   rd_data = '0;
        endcase
    end

    a_r10_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
        (check_en && rsp_valid && rsp_unc) |=> (cap_grp == $past(rsp_grp)));
    a_r11_no_count_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!check_en && !wr_en) |=> (cnt_flat == $past(cnt_flat)));
endmodule

// File: tb/ecc_inj_ctrl_bench.sv
module ecc_inj_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        inj_req, inj_double, irq_cor, irq_unc;
    logic [7:0]  inj_grp;
    logic [4:0]  inj_bit1, inj_bit2;
    logic [31:0] inj_data;
    logic        rsp_valid = 1'b0, rsp_cor = 1'b0, rsp_unc = 1'b0;
    logic [7:0]  rsp_grp = '0;
    logic [4:0]  rsp_bit = '0;
    int          n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    ecc_inj_ctrl u_ecc_inj_ctrl (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
        .inj_req, .inj_double, .inj_grp, .inj_bit1, .inj_bit2, .inj_data,
        .rsp_valid, .rsp_cor, .rsp_unc, .rsp_grp, .rsp_bit, .irq_cor, .irq_unc
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic respond(input logic [7:0] g, input logic [4:0] b, input logic c, input logic u);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_grp = g; rsp_bit = b; rsp_cor = c; rsp_unc = u;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_cor = 1'b0; rsp_unc = 1'b0;
    endtask

    task automatic clear_counts();
        wr(3'd4, 32'hFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(3'd0, d); check("R1 ctrl", d, 32'h4);
        rd(3'd1, d); check("R1 target", d, 0);
        rd(3'd2, d); check("R1 second", d, 0);
        rd(3'd3, d); check("R1 counts", d, 0);
        rd(3'd5, d); check("R1 capture", d, 0);
        check("R1 irq/req", {irq_cor, irq_unc, inj_req}, 0);
    endtask

    task automatic t_pattern();
        wr(3'd0, 32'h4); #1 check("R2 code0", inj_data, 32'h0);
        wr(3'd0, 32'h5); #1 check("R2 code1", inj_data, 32'hFFFFFFFF);
        wr(3'd0, 32'h6); #1 check("R2 code2", inj_data, 32'hAAAAAAAA);
        wr(3'd0, 32'h7); #1 check("R2 code3", inj_data, 32'h55555555);
        wr(3'd0, 32'h4);
    endtask

    task automatic t_single_step_wrap();
        logic [31:0] d;
        wr(3'd1, 32'h001F_0002);
        wr(3'd2, 32'h9);
        wr(3'd0, 32'h1C);  // check, step, force single
        check("R4 bit2 zero single", inj_bit2, 0);
        check("R3 no req yet", inj_req, 0);
        @(negedge clk);
        check("R3 req high in issue", inj_req, 1);
        check("R3 grp", inj_grp, 8'h02);
        check("R3 single", inj_double, 0);
        @(negedge clk);
        check("R3 req one cycle", inj_req, 0);
        // busy: target and force writes ignored
        wr(3'd1, 32'h0003_0011);
        rd(3'd1, d); check("R12 target held", d, 32'h001F_0002);
        wr(3'd0, 32'h0D);  // try clearing force, pattern=1
        rd(3'd0, d); check("R12 force kept, others written", d, 32'h1D);
        respond(8'h07, 5'd3, 1'b0, 1'b1);  // other group: real uncorrected
        rd(3'd3, d); check("R8 real unc", d, 32'h04);
        check("R9 irq_unc", irq_unc, 1);
        respond(8'h02, 5'd31, 1'b1, 1'b0);
        rd(3'd0, d); check("R3 force self-cleared", d, 32'h0D);
        rd(3'd1, d); check("R5 wrap to next group", d, 32'h0000_0003);
        rd(3'd3, d); check("R8 injected cor", d, 32'h14);
        check("R9 irq_cor", irq_cor, 1);
        rd(3'd5, d); check("R10 capture", d, 32'h001F_0002);
        clear_counts();
        check("R9 irqs low", {irq_cor, irq_unc}, 0);
    endtask

    task automatic t_double_nostep();
        logic [31:0] d;
        wr(3'd1, 32'h0004_0006);
        wr(3'd2, 32'h9);
        wr(3'd0, 32'h24);  // check, force double, no step
        check("R4 bit2 driven", inj_bit2, 5'd9);
        check("R3 double", inj_double, 1);
        @(negedge clk); @(negedge clk);
        respond(8'h06, 5'd4, 1'b0, 1'b1);
        rd(3'd1, d); check("R5 no step keeps target", d, 32'h0004_0006);
        rd(3'd0, d); check("R3 double cleared", d, 32'h04);
        rd(3'd3, d); check("R8 injected unc", d, 32'h40);
        clear_counts();
    endtask

    task automatic t_counts();
        logic [31:0] d;
        wr(3'd3, 32'h12);  // cor+2, icor+1
        rd(3'd3, d); check("R6 add", d, 32'h12);
        wr(3'd3, 32'h03);
        rd(3'd3, d); check("R6 saturate", d, 32'h13);
        wr(3'd4, 32'h01);
        rd(3'd3, d); check("R7 subtract", d, 32'h12);
        wr(3'd4, 32'h33);
        rd(3'd3, d); check("R7 floor zero", d, 32'h00);
        respond(8'h01, 5'd1, 1'b1, 1'b0);
        respond(8'h01, 5'd1, 1'b1, 1'b0);
        respond(8'h01, 5'd1, 1'b1, 1'b0);
        respond(8'h01, 5'd1, 1'b1, 1'b0);
        rd(3'd3, d); check("R8 event saturate", d, 32'h03);
        clear_counts();
    endtask

    task automatic t_check_off();
        logic [31:0] d, cap;
        rd(3'd5, cap);
        wr(3'd0, 32'h0);
        respond(8'h09, 5'd5, 1'b1, 1'b1);
        rd(3'd3, d); check("R11 no count", d, 0);
        rd(3'd5, d); check("R11 no capture", d, cap);
        wr(3'd0, 32'h4);
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pattern();
        t_single_step_wrap();
        t_double_nostep();
        t_counts();
        t_check_off();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule